// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block owns the command pins of a single-data-rate SDRAM from reset until the memory is ready for ordinary traffic. It first keeps the clock enable low for a programmable number of cycles while the device settles. It then raises the clock enable, issues one NOP and closes every bank with a precharge-all command. Next come a configurable number of auto-refresh commands, with at least two, and a write of the mode register. An optional write of the extended mode register follows. Each command is followed by NOP cycles that respect the device's minimum spacing.

The mode word always selects a read latency of three clocks and sequential burst ordering, and the burst length code is a parameter. When the last spacing interval has run out, `init_done` goes high and stays high. From then on the block drives only NOPs with the clock enable high, so a normal access engine can take over the pins.

The control is one state machine with these states: `ST_WAIT` (power-up hold), `ST_WAKE` (first NOP), `ST_PALL` and `ST_PALL_GAP` (precharge-all and its spacing), `ST_REF` and `ST_REF_GAP` (one refresh and its spacing, repeated), `ST_MRS` and `ST_MRS_GAP`, `ST_EMRS` and `ST_EMRS_GAP`, and `ST_READY`. The transitions are:
- WAIT→WAKE when the power-up timer expires.
- WAKE→PALL after one cycle.
- PALL→PALL_GAP→REF.
- REF→REF_GAP→REF until the last refresh, then REF_GAP→MRS.
- MRS→MRS_GAP, then MRS_GAP→EMRS when the extended write is enabled, otherwise MRS_GAP→READY.
- EMRS→EMRS_GAP→READY.

READY is terminal. All pins are registered, so every pin lags the state by one clock.

Top module: `sdram_pwrup_seq`

## Requirements
- R1: While reset is asserted, and for WAIT_CYCLES clocks after reset is released, `cke` is low, the command {cs_n,ras_n,cas_n,we_n} is 1111 (deselect) and `init_done` is low.
- R2: In the first cycle with `cke` high the command is NOP (0111). `cke` then stays high, and the next cycle carries the first real command.
- R3: The first real command is precharge-all: command 0010 with `addr[10]` = 1, all other address bits 0 and `ba` = 00.
- R4: The next command comes exactly T_RP clocks after the precharge, and every cycle in between is a NOP.
- R5: Exactly REFRESH_COUNT auto-refresh commands (0001, address and bank 0) are issued, each T_RFC clocks after the previous command. The command after the last refresh also follows it by T_RFC clocks.
- R6: The mode register write is command 0000 with `ba` = 00. Its address has `addr[6:4]` = 011 (latency three), `addr[3]` = 0 (sequential bursts), `addr[2:0]` = BURST_CODE, and all other bits 0.
- R7: When EMRS_EN is 1, an extended mode write (command 0000, `ba` = 10, `addr` = EMRS_WORD) follows the mode write by exactly T_MRD clocks. When EMRS_EN is 0, no command with `ba` = 10 is issued.
- R8: `init_done` rises exactly T_MRD clocks after the last mode write and then stays high.
- R9: Once `init_done` is high, every cycle is a NOP with `cke` high.
- R10: Exactly this order of non-NOP commands is issued and no other: precharge-all, the refreshes, the mode write, then the optional extended write.
- R11: Asserting reset at any point, including in the middle of the refresh phase, returns the pins to the R1 state, and the full sequence then restarts from the power-up hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, the same clock that drives the memory |
| rst_n | input | 1 | Active-low synchronous reset |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank address |
| addr | output | ADDR_W | Multiplexed address; carries the mode word during register writes |
| init_done | output | 1 | High once the sequence has completed |

## Verification
The hardest case to reach is a reset that lands partway through the refresh phase. The spacing timer and the refresh counter must then both restart cleanly, with no half-finished refresh or early mode write leaking out. To reach it, the bench counts logged refresh commands at the pins and pulls reset right after the first refresh. It then checks the deselect state, releases reset, and compares the entire new command log and every gap against the expected table. A second instance built with the extended write disabled and three refreshes checks that the refresh count is honoured and that the mode write is the final command.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

    // Command code on {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_LMR     = 4'b0000,
        CMD_AREF    = 4'b0001,
        CMD_PREALL  = 4'b0010,
        CMD_NOP     = 4'b0111,
        CMD_DESEL   = 4'b1111
    } sdram_cmd_t;

    typedef enum logic [3:0] {
        ST_WAIT,
        ST_WAKE,
        ST_PALL,
        ST_PALL_GAP,
        ST_REF,
        ST_REF_GAP,
        ST_MRS,
        ST_MRS_GAP,
        ST_EMRS,
        ST_EMRS_GAP,
        ST_READY
    } init_state_t;

    // Low seven bits of the mode word: latency 3, sequential, given burst code
    function automatic logic [6:0] mode_low_bits(input logic [2:0] burst_code);
        logic [6:0] w;
        w      = '0;
        w[2:0] = burst_code;
        w[3]   = 1'b0;
        w[6:4] = 3'b011;
        return w;
    endfunction

endpackage

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
    parameter int unsigned    CW      = 8,
    parameter logic [CW-1:0]  RST_VAL = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);

    logic [CW-1:0] count_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= RST_VAL;
        end else if (load) begin
            count_q <= load_val;
        end else if (count_q != '0) begin
            count_q <= count_q - 1'b1;
        end
    end

    assign expired = (count_q == '0);

    // R4 spacing counter parks at zero instead of wrapping
    timer_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && count_q == '0) |=> (count_q == '0));

endmodule

// File: rtl/sdram_init_cmd_reg.sv
module sdram_init_cmd_reg
    import sdram_init_pkg::*;
#(
    parameter int unsigned ADDR_W = 13,
    parameter int unsigned BA_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cke_d,
    input  sdram_cmd_t        cmd_d,
    input  logic [BA_W-1:0]   ba_d,
    input  logic [ADDR_W-1:0] addr_d,
    input  logic              done_d,
    output logic              cke,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [BA_W-1:0]   ba,
    output logic [ADDR_W-1:0] addr,
    output logic              init_done
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cke                      <= 1'b0;
            {cs_n,ras_n,cas_n,we_n}  <= CMD_DESEL;
            ba                       <= '0;
            addr                     <= '0;
            init_done                <= 1'b0;
        end else begin
            cke                      <= cke_d;
            {cs_n,ras_n,cas_n,we_n}  <= cmd_d;
            ba                       <= ba_d;
            addr                     <= addr_d;
            init_done                <= done_d;
        end
    end

endmodule

// File: rtl/sdram_pwrup_seq.sv
module sdram_pwrup_seq
    import sdram_init_pkg::*;
#(
    parameter int unsigned          ADDR_W        = 13,
    parameter int unsigned          BA_W          = 2,
    parameter int unsigned          WAIT_CYCLES   = 200,
    parameter int unsigned          T_RP          = 3,
    parameter int unsigned          T_RFC         = 11,
    parameter int unsigned          T_MRD         = 2,
    parameter int unsigned          REFRESH_COUNT = 2,
    parameter bit                   EMRS_EN       = 1'b1,
    parameter logic [2:0]           BURST_CODE    = 3'b000,
    parameter logic [ADDR_W-1:0]    EMRS_WORD     = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              cke,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [BA_W-1:0]   ba,
    output logic [ADDR_W-1:0] addr,
    output logic              init_done
);

    localparam int unsigned TMAX_A = (WAIT_CYCLES > T_RFC) ? WAIT_CYCLES : T_RFC;
    localparam int unsigned TMAX_B = (T_RP > T_MRD) ? T_RP : T_MRD;
    localparam int unsigned TMAX   = (TMAX_A > TMAX_B) ? TMAX_A : TMAX_B;
    localparam int unsigned CW     = $clog2(TMAX + 1);
    localparam int unsigned RCW    = $clog2(REFRESH_COUNT + 1);
    localparam logic [BA_W-1:0] EXT_BANK = BA_W'(2);

    init_state_t     state_q, state_d;
    logic [RCW-1:0]  ref_cnt_q;
    logic            t_load;
    logic [CW-1:0]   t_val;
    logic            t_exp;

    logic              cke_d;
    sdram_cmd_t        cmd_d;
    logic [BA_W-1:0]   ba_d;
    logic [ADDR_W-1:0] addr_d;
    logic              done_d;

    sdram_init_timer #(
        .CW      (CW),
        .RST_VAL (CW'(WAIT_CYCLES - 1))
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .expired  (t_exp)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_WAIT;
        end else begin
            state_q <= state_d;
        end
    end

    // refresh counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_cnt_q <= '0;
        end else if (state_q == ST_REF) begin
            ref_cnt_q <= ref_cnt_q + 1'b1;
        end
    end

    // next state and spacing timer control
    always_comb begin
        state_d = state_q;
        t_load  = 1'b0;
        t_val   = '0;
        unique case (state_q)
            ST_WAIT: begin
                if (t_exp) state_d = ST_WAKE;
            end
            ST_WAKE: begin
                state_d = ST_PALL;
            end
            ST_PALL: begin
                state_d = ST_PALL_GAP;
                t_load  = 1'b1;
                t_val   = CW'(T_RP - 2);
            end
            ST_PALL_GAP: begin
                if (t_exp) state_d = ST_REF;
            end
            ST_REF: begin
                state_d = ST_REF_GAP;
                t_load  = 1'b1;
                t_val   = CW'(T_RFC - 2);
            end
            ST_REF_GAP: begin
                if (t_exp) begin
                    if (ref_cnt_q == RCW'(REFRESH_COUNT)) state_d = ST_MRS;
                    else                                   state_d = ST_REF;
                end
            end
            ST_MRS: begin
                state_d = ST_MRS_GAP;
                t_load  = 1'b1;
                t_val   = CW'(T_MRD - 2);
            end
            ST_MRS_GAP: begin
                if (t_exp) state_d = EMRS_EN ? ST_EMRS : ST_READY;
            end
            ST_EMRS: begin
                state_d = ST_EMRS_GAP;
                t_load  = 1'b1;
                t_val   = CW'(T_MRD - 2);
            end
            ST_EMRS_GAP: begin
                if (t_exp) state_d = ST_READY;
            end
            ST_READY: begin
                state_d = ST_READY;
            end
            default: begin
                state_d = ST_WAIT;
            end
        endcase
    end

    // pin decode for the current state
    always_comb begin
        cke_d  = 1'b1;
        cmd_d  = CMD_NOP;
        ba_d   = '0;
        addr_d = '0;
        done_d = 1'b0;
        unique case (state_q)
            ST_WAIT: begin
                cke_d = 1'b0;
                cmd_d = CMD_DESEL;
            end
            ST_PALL: begin
                cmd_d      = CMD_PREALL;
                addr_d[10] = 1'b1;
            end
            ST_REF: begin
                cmd_d = CMD_AREF;
            end
            ST_MRS: begin
                cmd_d       = CMD_LMR;
                addr_d[6:0] = mode_low_bits(BURST_CODE);
            end
            ST_EMRS: begin
                cmd_d  = CMD_LMR;
                ba_d   = EXT_BANK;
                addr_d = EMRS_WORD;
            end
            ST_READY: begin
                done_d = 1'b1;
            end
            ST_WAKE, ST_PALL_GAP, ST_REF_GAP, ST_MRS_GAP, ST_EMRS_GAP: begin
                cmd_d = CMD_NOP;
            end
            default: begin
                cke_d = 1'b0;
                cmd_d = CMD_DESEL;
            end
        endcase
    end

    sdram_init_cmd_reg #(
        .ADDR_W (ADDR_W),
        .BA_W   (BA_W)
    ) u_pins (
        .clk       (clk),
        .rst_n     (rst_n),
        .cke_d     (cke_d),
        .cmd_d     (cmd_d),
        .ba_d      (ba_d),
        .addr_d    (addr_d),
        .done_d    (done_d),
        .cke       (cke),
        .cs_n      (cs_n),
        .ras_n     (ras_n),
        .cas_n     (cas_n),
        .we_n      (we_n),
        .ba        (ba),
        .addr      (addr),
        .init_done (init_done)
    );

    logic [3:0] pin_cmd;
    assign pin_cmd = {cs_n, ras_n, cas_n, we_n};

    // R1
    wait_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |-> (pin_cmd == 4'b1111 && !init_done));

    // R2
    cke_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cke |=> cke);

    // R3
    pall_a10_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_cmd == 4'b0010) |-> addr[10]);

    // R4
    pall_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_cmd == 4'b0010) |=> (pin_cmd == 4'b0111));

    // R5
    ref_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_cmd == 4'b0001) |=> (pin_cmd == 4'b0111));

    // R5
    ref_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ref_cnt_q <= RCW'(REFRESH_COUNT));

    // R8
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    // R9
    ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> (cke && pin_cmd == 4'b0111));

endmodule

// File: tb/sdram_pwrup_seq_bench.sv
module sdram_pwrup_seq_bench;

    localparam int CLK_PERIOD = 10;
    localparam int W     = 12;
    localparam int TRP   = 3;
    localparam int TRFC  = 11;
    localparam int TMRD  = 2;
    localparam logic [12:0] EXT_WORD = 13'h0020;
    // mode word: [6:4]=011, [3]=0, [2:0]=010
    localparam logic [12:0] MODE_EXP = 13'h0032;

    // {cmd[3:0], ba[1:0], addr[12:0], gap[7:0]}
    localparam logic [26:0] EXP_TAB [5] = '{
        {4'b0010, 2'b00, 13'h0400, 8'd0},
        {4'b0001, 2'b00, 13'h0000, 8'(TRP)},
        {4'b0001, 2'b00, 13'h0000, 8'(TRFC)},
        {4'b0000, 2'b00, MODE_EXP, 8'(TRFC)},
        {4'b0000, 2'b10, EXT_WORD, 8'(TMRD)}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic        cke, cs_n, ras_n, cas_n, we_n, init_done;
    logic [1:0]  ba;
    logic [12:0] addr;
    logic        cke2, cs2, ras2, cas2, we2, done2;
    logic [1:0]  ba2;
    logic [12:0] addr2;

    sdram_pwrup_seq #(
        .WAIT_CYCLES (W), .T_RP (TRP), .T_RFC (TRFC), .T_MRD (TMRD),
        .REFRESH_COUNT (2), .EMRS_EN (1'b1), .BURST_CODE (3'b010),
        .EMRS_WORD (EXT_WORD)
    ) u_sdram_pwrup_seq (
        .clk (clk), .rst_n (rst_n), .cke (cke), .cs_n (cs_n), .ras_n (ras_n),
        .cas_n (cas_n), .we_n (we_n), .ba (ba), .addr (addr), .init_done (init_done)
    );

    sdram_pwrup_seq #(
        .WAIT_CYCLES (3), .T_RP (2), .T_RFC (4), .T_MRD (3),
        .REFRESH_COUNT (3), .EMRS_EN (1'b0), .BURST_CODE (3'b111),
        .EMRS_WORD (13'h1fff)
    ) u_sdram_pwrup_seq_alt (
        .clk (clk), .rst_n (rst_n), .cke (cke2), .cs_n (cs2), .ras_n (ras2),
        .cas_n (cas2), .we_n (we2), .ba (ba2), .addr (addr2), .init_done (done2)
    );

    int tests = 0;
    int fails = 0;
    int cyc = 0;

    task automatic chk(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    // pin logger, main instance
    int          n_log;
    int          log_cyc  [16];
    logic [3:0]  log_cmd  [16];
    logic [1:0]  log_ba   [16];
    logic [12:0] log_addr [16];
    int          first_cke, done_cyc;
    logic [3:0]  wake_cmd;
    int          wait_bad, post_bad;

    // pin logger, alternate instance
    int n_ref2, n_mrs2, n_ext2, mrs_cyc2, done_cyc2, n_after2;

    always @(negedge clk) begin
        if (!rst_n) begin
            n_log = 0; first_cke = -1; done_cyc = -1; wake_cmd = 4'hx;
            wait_bad = 0; post_bad = 0;
            n_ref2 = 0; n_mrs2 = 0; n_ext2 = 0; mrs_cyc2 = -1; done_cyc2 = -1; n_after2 = 0;
        end else begin
            if (!cke && ({cs_n,ras_n,cas_n,we_n} != 4'b1111 || init_done)) wait_bad++;
            if (cke && first_cke < 0) begin
                first_cke = cyc;
                wake_cmd  = {cs_n,ras_n,cas_n,we_n};
            end
            if (!cs_n && {cs_n,ras_n,cas_n,we_n} != 4'b0111 && n_log < 16) begin
                log_cyc[n_log]  = cyc;
                log_cmd[n_log]  = {cs_n,ras_n,cas_n,we_n};
                log_ba[n_log]   = ba;
                log_addr[n_log] = addr;
                n_log++;
            end
            if (done_cyc >= 0 && (!init_done || !cke || {cs_n,ras_n,cas_n,we_n} != 4'b0111))
                post_bad++;
            if (init_done && done_cyc < 0) done_cyc = cyc;

            if ({cs2,ras2,cas2,we2} == 4'b0001) n_ref2++;
            if ({cs2,ras2,cas2,we2} == 4'b0000) begin
                n_mrs2++;
                mrs_cyc2 = cyc;
                if (ba2 == 2'b10) n_ext2++;
                if (addr2 != 13'h0037) n_ext2 += 100;
            end
            if (done2 && done_cyc2 < 0) done_cyc2 = cyc;
            if (done_cyc2 >= 0 && {cs2,ras2,cas2,we2} != 4'b0111) n_after2++;
        end
    end

    task automatic check_log(input string pass);
        chk({pass, " R10 command count"}, n_log, 5);
        for (int i = 0; i < 5; i++) begin
            chk($sformatf("%s R3/R5/R6/R7 cmd[%0d]", pass, i), int'(log_cmd[i]), int'(EXP_TAB[i][26:23]));
            chk($sformatf("%s R3/R6/R7 ba[%0d]", pass, i), int'(log_ba[i]), int'(EXP_TAB[i][22:21]));
            chk($sformatf("%s R3/R6/R7 addr[%0d]", pass, i), int'(log_addr[i]), int'(EXP_TAB[i][20:8]));
            if (i > 0)
                chk($sformatf("%s R4/R5/R7 gap[%0d]", pass, i),
                    log_cyc[i] - log_cyc[i-1], int'(EXP_TAB[i][7:0]));
        end
        chk({pass, " R1 wait length"}, first_cke, W + 1);
        chk({pass, " R2 wake NOP"}, int'(wake_cmd), 4'b0111);
        chk({pass, " R2 first command next cycle"}, log_cyc[0] - first_cke, 1);
        chk({pass, " R8 done spacing"}, done_cyc - log_cyc[4], TMRD);
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 cke in reset", int'(cke), 0);
        chk("R1 deselect in reset", int'({cs_n,ras_n,cas_n,we_n}), 4'b1111);
        chk("R1 done in reset", int'(init_done), 0);
        rst_n = 1'b1;

        while (!(init_done && done2)) @(negedge clk);
        repeat (30) @(negedge clk);
        check_log("run1");
        chk("R1 wait deselect", wait_bad, 0);
        chk("R8/R9 idle after done", post_bad, 0);
        // alternate build
        chk("R5 alt refresh count", n_ref2, 3);
        chk("R7 alt no extended write", n_ext2, 0);
        chk("R6 alt single mode write", n_mrs2, 1);
        chk("R8 alt done spacing", done_cyc2 - mrs_cyc2, 3);
        chk("R9 alt idle after done", n_after2, 0);

        // R11 reset in the refresh phase
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        while (n_log < 2) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R11 cke after mid reset", int'(cke), 0);
        chk("R11 deselect after mid reset", int'({cs_n,ras_n,cas_n,we_n}), 4'b1111);
        chk("R11 done after mid reset", int'(init_done), 0);
        @(negedge clk);
        rst_n = 1'b1;
        while (!init_done) @(negedge clk);
        repeat (10) @(negedge clk);
        check_log("R11 rerun");
        chk("R11 idle after done", post_bad, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule